// File: doc/BRIEF.md
# Mains Half-Cycle Power-Fail Detector

This block decides from two digital comparator outputs whether mains power has failed. The first input pulses once per half-cycle of a full-wave rectified line while the line is above the lower threshold. The second input goes high when the line is above a higher threshold, which marks it as fit for restart. Every rising edge of the pulse input restarts a missing-pulse timer. The timeout is longer than one rectified period, so a healthy line keeps the timer running and never lets it run out. If even one half-cycle is missing, the timer expires. This sets a sticky power-low flag, and that flag drives an interrupt request.

The power-fail decision is never withdrawn by the detector itself. Pulses that resume at once do not clear the flag. Only the clear input does, and in a system that input is driven by the restart sequencer. A rising edge on the higher-threshold input is passed on as a single-cycle power-up event for that sequencer.

All pins are plain level or pulse control signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. Both comparator inputs pass through a synchronizer of `SYNC_STAGES` flops (default 2). The clear input is taken as already synchronous.

Top module: `pfd_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `power_low_o`=0, `irq_o`=0, `line_good_o`=1 and `up_event_o`=0. Reset arms the timer as a pulse would. With no pulses after reset, `line_good_o` falls at the TIMEOUT_CYC-th rising clock edge after the last reset edge, and `power_low_o` rises one edge later.
- R2: A rising edge on `cmp_low_i` that is first sampled at clock edge A re-arms the timer at edge A+2. Pulses whose rising edges are at most TIMEOUT_CYC cycles apart keep `power_low_o` at 0.
- R3: If no re-arm follows the re-arm at edge E, `power_low_o` rises at edge E+TIMEOUT_CYC+1. A pulse spacing of TIMEOUT_CYC+1 cycles is therefore a failure.
- R4: `irq_o` is high exactly while `power_low_o` is high.
- R5: Once set, `power_low_o` stays high whatever happens on `cmp_low_i`, until a clear or a reset.
- R6: `clr_low_i` high at a clock edge with no expiry at that edge clears `power_low_o` at that edge.
- R7: If an expiry and `clr_low_i` meet at the same edge, the flag is set (set wins).
- R8: A rising edge on `cmp_high_i` that is first sampled at edge A gives `up_event_o`=1 for exactly the one cycle after edge A+1. Holding the input high or letting it fall gives no further event.
- R9: An expiry fires once per outage. After it, `line_good_o` stays 0 and the timer stays idle until the next re-arm. A clear during that idle time leaves `power_low_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_low_i | input | 1 | Lower-threshold comparator, one pulse per half-cycle |
| cmp_high_i | input | 1 | Upper-threshold comparator, high when line fits restart |
| clr_low_i | input | 1 | Synchronous clear of the power-low flag |
| power_low_o | output | 1 | Sticky power-fail flag |
| irq_o | output | 1 | Interrupt request, high while the flag is set |
| up_event_o | output | 1 | One-cycle power-up event |
| line_good_o | output | 1 | Timer armed, pulses arriving in time |

## Verification
The latencies are fixed. A pulse edge re-arms the timer two edges after it is first sampled. The flag follows the last re-arm by TIMEOUT_CYC+1 edges. The up event appears one edge after its input is first sampled, and a clear acts at the edge where it is seen. The bench drives its inputs on falling edges and counts falling edges from each drive point. It samples exactly at the cycle these latencies give, and for the timeout and the pulse-spacing boundary it also samples one cycle earlier to confirm the output has not yet changed. The set-wins case places the clear on the very edge that the expiry reaches, which the same count fixes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned CMP_W    = 2;
  localparam int unsigned CMP_LOW  = 0;
  localparam int unsigned CMP_HIGH = 1;

  typedef logic [CMP_W-1:0] cmp_vec_t;

  typedef enum logic {
    TMR_IDLE  = 1'b0,
    TMR_ARMED = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] = lvl_i[b] & ~prev_q[b];
    end
  endgenerate
endmodule

// File: rtl/pfd_watchdog.sv
module pfd_watchdog
  import pfd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 750000
) (
  input  logic clk,
  input  logic rst,
  input  logic rearm_i,
  output logic expire_o,
  output logic armed_o
);
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  tmr_state_e    state_q;
  logic          expire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      state_q  <= TMR_ARMED;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (rearm_i) begin
        cnt_q   <= '0;
        state_q <= TMR_ARMED;
      end else if (state_q == TMR_ARMED) begin
        if (cnt_q == LIMIT) begin
          state_q  <= TMR_IDLE;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign expire_o = expire_q;
  assign armed_o  = (state_q == TMR_ARMED);
endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pfd_monitor.sv
module pfd_monitor
  import pfd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 750000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_low_i,
  input  logic cmp_high_i,
  input  logic clr_low_i,
  output logic power_low_o,
  output logic irq_o,
  output logic up_event_o,
  output logic line_good_o
);
  cmp_vec_t raw_cmp;
  cmp_vec_t sync_cmp;
  cmp_vec_t cmp_rise;
  logic     pulse_rise;
  logic     expire;
  logic     low_flag;

  assign raw_cmp[CMP_LOW]  = cmp_low_i;
  assign raw_cmp[CMP_HIGH] = cmp_high_i;

  pfd_sync #(.STAGES(SYNC_STAGES), .WIDTH(CMP_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_cmp),
    .q_o (sync_cmp)
  );

  pfd_edge #(.WIDTH(CMP_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sync_cmp),
    .rise_o (cmp_rise)
  );

  assign pulse_rise = cmp_rise[CMP_LOW];

  pfd_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .rearm_i  (pulse_rise),
    .expire_o (expire),
    .armed_o  (line_good_o)
  );

  pfd_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (expire),
    .clr_i  (clr_low_i),
    .flag_o (low_flag)
  );

  assign power_low_o = low_flag;
  assign irq_o       = low_flag;
  assign up_event_o  = cmp_rise[CMP_HIGH];
endmodule

// File: rtl/pfd_monitor_chk.sv
module pfd_monitor_chk (
  input logic clk,
  input logic rst,
  input logic clr_low_i,
  input logic power_low_o,
  input logic up_event_o,
  input logic line_good_o,
  input logic rise,
  input logic expire
);
  // R5: the flag holds without a clear
  a_r5_latched: assert property (@(posedge clk) disable iff (rst)
    (power_low_o && !clr_low_i) |=> power_low_o);

  // R6: a clear with no expiry drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_low_i && !expire) |=> !power_low_o);

  // R7: an expiry always sets the flag, clear or not
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> power_low_o);

  // R3: the flag only rises from a timer expiry
  a_r3_rise_from_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(power_low_o) |-> $past(expire));

  // R8: the up event lasts one cycle
  a_r8_up_single: assert property (@(posedge clk) disable iff (rst)
    up_event_o |=> !up_event_o);

  // R9: the idle timer stays idle until a re-arm
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!line_good_o && !rise) |=> !line_good_o);

  // R2: a re-arm leaves the timer armed
  a_r2_rearm: assert property (@(posedge clk) disable iff (rst)
    rise |=> line_good_o);
endmodule

bind pfd_monitor pfd_monitor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_low_i   (clr_low_i),
  .power_low_o (power_low_o),
  .up_event_o  (up_event_o),
  .line_good_o (line_good_o),
  .rise        (pulse_rise),
  .expire      (expire)
);

// File: tb/tb_pfd_monitor.sv
`timescale 1ns/1ps
module tb_pfd_monitor;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_low = 1'b0;
  logic cmp_high = 1'b0;
  logic clr_low = 1'b0;
  logic power_low, irq, up_event, line_good;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pfd_monitor #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
    .clk (clk), .rst (rst), .cmp_low_i (cmp_low), .cmp_high_i (cmp_high),
    .clr_low_i (clr_low), .power_low_o (power_low), .irq_o (irq),
    .up_event_o (up_event), .line_good_o (line_good)
  );

  // fields: {clr, expected flag, pulse count[5:0], period[7:0]}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd8, 8'd10},
    {1'b0, 1'b0, 6'd5, 8'd25},
    {1'b0, 1'b0, 6'd4, 8'd38},
    {1'b0, 1'b1, 6'd2, 8'd60},
    {1'b0, 1'b1, 6'd6, 8'd10},
    {1'b1, 1'b0, 6'd0, 8'd0},
    {1'b0, 1'b0, 6'd6, 8'd20},
    {1'b0, 1'b1, 6'd2, 8'd45},
    {1'b1, 1'b0, 6'd0, 8'd0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one-cycle pulse, then low for period-1 cycles
  task automatic pulse(input int period);
    cmp_low = 1'b1;
    step(1);
    cmp_low = 1'b0;
    step(period - 1);
  endtask

  task automatic clear_flag();
    clr_low = 1'b1;
    step(1);
    clr_low = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    // R1: reset state
    chk("R1 reset power_low", power_low, 1'b0);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset line_good", line_good, 1'b1);
    chk("R1 reset up_event", up_event, 1'b0);
    rst = 1'b0;
    // R1/R3: timer armed by reset, no pulses
    step(TMO);
    chk("R1 line_good drops at timeout", line_good, 1'b0);
    chk("R1 flag not yet set", power_low, 1'b0);
    step(1);
    chk("R1 flag set one edge later", power_low, 1'b1);
    chk("R4 irq with flag", irq, 1'b1);
    clear_flag();

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][15]) begin
        clear_flag();
      end else begin
        for (int p = 0; p < int'(VEC[v][13:8]); p++) pulse(int'(VEC[v][7:0]));
      end
      chk($sformatf("R2/R3/R5/R6 vector %0d flag", v), power_low, VEC[v][14]);
      chk($sformatf("R4 vector %0d irq", v), irq, VEC[v][14]);
    end

    // R2 boundary: spacing of exactly TMO keeps the line good
    pulse(10);
    clear_flag();
    for (int p = 0; p < 5; p++) pulse(TMO);
    chk("R2 spacing TMO no fail", power_low, 1'b0);
    chk("R2 spacing TMO line_good", line_good, 1'b1);
    // R3 boundary: spacing of TMO+1 fails, exact cycle
    cmp_low = 1'b1; step(1); cmp_low = 1'b0;
    step(TMO + 2);
    chk("R3 flag clear one cycle before", power_low, 1'b0);
    step(1);
    chk("R3 flag set at E+TMO+1", power_low, 1'b1);
    pulse(10);
    chk("R5 pulse resumed flag held", power_low, 1'b1);

    // R7: clear on the very edge of the expiry
    pulse(10);
    clear_flag();
    chk("R6 clear with pulses present", power_low, 1'b0);
    cmp_low = 1'b1; step(1); cmp_low = 1'b0;
    step(TMO + 2);
    chk("R7 flag clear before collision", power_low, 1'b0);
    clr_low = 1'b1;
    step(1);
    clr_low = 1'b0;
    chk("R7 set wins over clear", power_low, 1'b1);

    // R9: idle timer, clear during outage
    step(5);
    chk("R9 line_good low after expiry", line_good, 1'b0);
    clear_flag();
    step(3 * TMO);
    chk("R9 no second expiry", power_low, 1'b0);
    chk("R9 still idle", line_good, 1'b0);
    cmp_low = 1'b1; step(1); cmp_low = 1'b0;
    step(1);
    chk("R9 idle before re-arm edge", line_good, 1'b0);
    step(1);
    chk("R9 re-armed by pulse", line_good, 1'b1);

    // R8: up event timing and single cycle
    cmp_high = 1'b1;
    step(1);
    chk("R8 no event after first sample", up_event, 1'b0);
    step(1);
    chk("R8 event after second edge", up_event, 1'b1);
    step(1);
    chk("R8 event lasts one cycle", up_event, 1'b0);
    step(8);
    chk("R8 no event while held", up_event, 1'b0);
    cmp_high = 1'b0;
    step(2);
    chk("R8 no event on fall", up_event, 1'b0);
    step(1);
    chk("R8 no event after fall", up_event, 1'b0);

    // R1: reset during a latched failure
    step(TMO + 5);
    chk("R3 failed before reset", power_low, 1'b1);
    rst = 1'b1;
    step(2);
    chk("R1 reset clears flag", power_low, 1'b0);
    chk("R1 reset re-arms", line_good, 1'b1);
    rst = 1'b0;
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule